// File: doc/BRIEF.md
# Startup and Hiccup Fault Sequencer

This block decides when a boost converter may switch. It runs on the switching clock and takes four inputs: a power-on reset, the PWM dimming input, and two protection comparator results, one for over-voltage and one for over-current. It drives a gate-enable for the switching FET driver and a release command for the compensation node. It also drives a discharge command for that node and a fault status.

After power-up the converter stays off and the compensation capacitor is held discharged. This lasts until the dimming input shows its first low-to-high transition. A counted delay then starts: a prescaler divides the switching clock, and a tick counter counts to its terminal value. Only when the count expires are the gate driver and the compensation node released. A protection fault at any time shuts the converter down and holds the delay counter at zero. When the fault goes away, the converter restarts through the same delay, which gives hiccup-mode protection whose period follows the switching frequency.

Top module: `hiccup_seq`

## Requirements
- R1: During and right after reset, fault_flag and comp_discharge are 1, and gate_en and comp_release are 0.
- R2: After reset the block stays off until dim_in goes from 0 to 1. A dim_in already high during reset does not count as that transition. A fault present during this wait does not start the delay.
- R3: After the first rising edge of dim_in is sampled at clock edge E0, gate_en and comp_release become 1 (with dim_in high) after edge E0+PRE_DIV*DELAY_TICKS, which is edge E0+1024 for the defaults. They are still 0 after edge E0+1023.
- R4: ov_in and oc_in each pass through two flip-flops. A fault raised before edge F1 turns the outputs off after edge F2 and not after edge F1.
- R5: While a synchronized fault is present, gate_en and comp_release are 0, comp_discharge and fault_flag are 1, and the delay counter is held at zero.
- R6: When a fault input falls before edge C1, the restart delay begins at edge C3. Release happens after edge C3+1024, so the outputs read released after edge C1027 and not after edge C1026.
- R7: comp_discharge and fault_flag are both 1 exactly when the block is not released. Neither is ever 1 together with gate_en or comp_release.
- R8: A fault that arrives while the delay is counting discards the partial count. The full delay runs again once the fault clears.
- R9: In the released state, dim_in low forces gate_en and comp_release to 0 in the same cycle. dim_in high enables them again with no new delay, and comp_discharge stays 0.
- R10: The released state persists for any length of time until a fault or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| dim_in | input | 1 | PWM dimming input, high means LEDs on |
| ov_in | input | 1 | Over-voltage comparator result, asynchronous |
| oc_in | input | 1 | Over-current comparator result, asynchronous |
| gate_en | output | 1 | Switching gate driver enable |
| comp_release | output | 1 | Lets the error amplifier drive the compensation node |
| comp_discharge | output | 1 | Pulls the compensation node low |
| fault_flag | output | 1 | High while starting up or in fault |

## Verification
The bench builds the block with its default values: a prescale of 4, 256 delay ticks and two synchronizer stages. With these values the full 1024-cycle restart delay can be checked to the exact edge. Each delay run lasts about a thousand cycles, so the bench can step through a cold start, a restart after over-voltage, and a restart after an over-current pulse in the middle of a count. It can also cover a fault that overlaps the power-up wait. The two-stage synchronizer latency is checked one edge on each side.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    typedef enum logic [1:0] {
        SEQ_PWRUP = 2'd0,
        SEQ_FAULT = 2'd1,
        SEQ_DELAY = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic gate_en;
        logic comp_release;
        logic comp_discharge;
        logic fault_flag;
    } seq_out_t;

    function automatic seq_out_t seq_decode(input logic released, input logic dim);
        seq_out_t o;
        o.gate_en        = released & dim;
        o.comp_release   = released & dim;
        o.comp_discharge = ~released;
        o.fault_flag     = ~released;
        return o;
    endfunction

    function automatic seq_state_e seq_next(
        input seq_state_e cur,
        input logic       dim_rise,
        input logic       fault_now,
        input logic       expire
    );
        seq_state_e n;
        n = cur;
        unique case (cur)
            SEQ_PWRUP: if (dim_rise) n = fault_now ? SEQ_FAULT : SEQ_DELAY;
            SEQ_FAULT: if (!fault_now) n = SEQ_DELAY;
            SEQ_DELAY: begin
                if (fault_now)   n = SEQ_FAULT;
                else if (expire) n = SEQ_RUN;
            end
            SEQ_RUN:   if (fault_now) n = SEQ_FAULT;
            default:   n = SEQ_PWRUP;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/hsq_sync.sv
module hsq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsq_tick_gen.sv
module hsq_tick_gen #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || !run)    pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                pre <= pre + 1'b1;
    end

    assign tick = run && (pre == LAST);
endmodule

// File: rtl/hsq_delay_cnt.sv
module hsq_delay_cnt #(
    parameter int DELAY_TICKS = 256,
    localparam int CW = $clog2(DELAY_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    output logic          expire,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) count <= '0;
        else if (tick)   count <= count + 1'b1;
    end

    assign expire = run && tick && (count == LAST);
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
    parameter int PRE_DIV     = 4,
    parameter int DELAY_TICKS = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dim_in,
    input  logic ov_in,
    input  logic oc_in,
    output logic gate_en,
    output logic comp_release,
    output logic comp_discharge,
    output logic fault_flag
);
    import hsq_pkg::*;

    localparam int DLY_W = $clog2(DELAY_TICKS + 1);

    logic [1:0]       flt_sync;
    logic             fault_now;
    logic             dim_q;
    logic             dim_rise;
    seq_state_e       state;
    seq_state_e       state_nxt;
    logic             run_delay;
    logic             tick;
    logic             expire;
    logic [DLY_W-1:0] count;
    logic             released;
    seq_out_t         outs;

    hsq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ov_in, oc_in}),
        .q   (flt_sync)
    );

    assign fault_now = |flt_sync;

    // A dim input already high at reset is not a rising edge.
    always_ff @(posedge clk) begin
        if (rst) dim_q <= 1'b1;
        else     dim_q <= dim_in;
    end

    assign dim_rise = dim_in & ~dim_q;

    assign run_delay = (state == SEQ_DELAY) && !fault_now;

    hsq_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run_delay),
        .tick (tick)
    );

    hsq_delay_cnt #(.DELAY_TICKS(DELAY_TICKS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run_delay),
        .tick   (tick),
        .expire (expire),
        .count  (count)
    );

    assign state_nxt = seq_next(state, dim_rise, fault_now, expire);

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_PWRUP;
        else     state <= state_nxt;
    end

    assign released = (state == SEQ_RUN) && !fault_now;
    assign outs     = seq_decode(released, dim_in);

    assign gate_en        = outs.gate_en;
    assign comp_release   = outs.comp_release;
    assign comp_discharge = outs.comp_discharge;
    assign fault_flag     = outs.fault_flag;
endmodule

// File: rtl/hsq_checker.sv
module hsq_checker #(
    parameter int DELAY_TICKS = 256,
    localparam int CW = $clog2(DELAY_TICKS + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                dim_in,
    input logic                ov_in,
    input logic                oc_in,
    input logic                gate_en,
    input logic                comp_release,
    input logic                comp_discharge,
    input logic                fault_flag,
    input logic                fault_now,
    input logic                expire,
    input logic [1:0]          state,
    input logic [CW-1:0]       count
);
    // Assumes the default two-stage synchronizer.
    p_gate_off_fault_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(ov_in, 2) || $past(oc_in, 2)) |-> (!gate_en && !comp_release));

    p_cnt_zero_fault_r5: assert property (@(posedge clk) disable iff (rst)
        fault_now |=> (count == '0));

    p_pwrup_held_r2: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0) |-> (count == '0 && fault_flag));

    p_disch_excl_r7: assert property (@(posedge clk) disable iff (rst)
        comp_discharge |-> (!gate_en && !comp_release));

    p_flag_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        fault_flag == comp_discharge);

    p_release_after_expire_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_flag) |-> ($past(expire) || $past(fault_now)));

    p_gate_needs_dim_r9: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> dim_in);
endmodule

bind hiccup_seq hsq_checker #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .dim_in         (dim_in),
    .ov_in          (ov_in),
    .oc_in          (oc_in),
    .gate_en        (gate_en),
    .comp_release   (comp_release),
    .comp_discharge (comp_discharge),
    .fault_flag     (fault_flag),
    .fault_now      (fault_now),
    .expire         (expire),
    .state          (state),
    .count          (count)
);

// File: tb/hiccup_seq_test.sv
`timescale 1ns/1ps
module hiccup_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dim_in = 1'b0;
    logic ov_in = 1'b0;
    logic oc_in = 1'b0;
    logic gate_en, comp_release, comp_discharge, fault_flag;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [3:0] OFF  = 4'b0011; // {gate,release,discharge,flag}
    localparam logic [3:0] ON   = 4'b1100;
    localparam logic [3:0] IDLE = 4'b0000;

    always #2.5 clk = ~clk;

    hiccup_seq uut (
        .clk            (clk),
        .rst            (rst),
        .dim_in         (dim_in),
        .ov_in          (ov_in),
        .oc_in          (oc_in),
        .gate_en        (gate_en),
        .comp_release   (comp_release),
        .comp_discharge (comp_discharge),
        .fault_flag     (fault_flag)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {gate_en, comp_release, comp_discharge, fault_flag};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic dim_lvl);
        rst = 1'b1; dim_in = dim_lvl; ov_in = 1'b0; oc_in = 1'b0;
        step(3);
        check("R1 in reset", OFF);
        rst = 1'b0;
        step(1);
        check("R1 after reset", OFF);
    endtask

    // R2: high level at reset is not a rising edge; then a real edge starts the delay
    task automatic t_pwrup_hold();
        do_reset(1'b1);
        step(1100);
        check("R2 held high level", OFF);
        dim_in = 1'b0;
        step(2);
        check("R2 low level", OFF);
        dim_in = 1'b1;
        step(1024);
        check("R3 one edge early", OFF);
        step(1);
        check("R3 released on time", ON);
    endtask

    // R3 cold start, R10 sticky, R9 dimming gating
    task automatic t_startup_dim();
        do_reset(1'b0);
        step(2);
        dim_in = 1'b1;
        step(1024);
        check("R3 before expiry", OFF);
        step(1);
        check("R3 at expiry", ON);
        step(700);
        check("R10 still released", ON);
        dim_in = 1'b0;
        #0.5;
        check("R9 dim low same cycle", IDLE);
        step(40);
        check("R9 dim low held", IDLE);
        dim_in = 1'b1;
        step(1);
        check("R9 no new delay", ON);
    endtask

    // R4 sync latency, R5 hold, R6 restart (expects released state on entry)
    task automatic t_ov_hiccup();
        ov_in = 1'b1;
        step(1);
        check("R4 one edge only", ON);
        step(1);
        check("R4 two edges", OFF);
        step(300);
        check("R5 over-voltage held", OFF);
        ov_in = 1'b0;
        step(1026);
        check("R6 one edge early", OFF);
        step(1);
        check("R6 restart on time", ON);
    endtask

    // R8 mid-count over-current restarts the whole delay
    task automatic t_oc_midcount();
        do_reset(1'b0);
        step(2);
        dim_in = 1'b1;
        step(600);
        oc_in = 1'b1;
        step(5);
        check("R5 over-current held", OFF);
        oc_in = 1'b0;
        step(1026);
        check("R8 partial count discarded", OFF);
        step(1);
        check("R8 full delay then release", ON);
    endtask

    // R2/R5 fault overlapping the power-up wait
    task automatic t_fault_in_pwrup();
        do_reset(1'b0);
        ov_in = 1'b1;
        step(20);
        check("R2 fault during wait", OFF);
        dim_in = 1'b1;
        step(1500);
        check("R5 fault blocks delay", OFF);
        ov_in = 1'b0;
        step(1026);
        check("R6 after pwrup fault early", OFF);
        step(1);
        check("R6 after pwrup fault", ON);
    endtask

    initial begin
        @(negedge clk);
        t_pwrup_hold();
        t_startup_dim();
        t_ov_hiccup();
        t_oc_midcount();
        t_fault_in_pwrup();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule